// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This block is a memory-mapped real-time clock on a plain 32-bit register bus with a select, a write enable, a 12-bit byte offset, write data and read data. A prescaler divides the bus clock by `CLK_HZ` to make a one-cycle tick once per second. Each tick advances a 32-bit seconds counter, which wraps at 2^32.

Software can preset the counter by writing a value and can program a match value. When the counter steps onto the match value, a one-bit raw interrupt flag latches. That flag is gated by a one-bit mask to give a level-high interrupt line. Software clears the flag by writing a one to its clear location. Fixed identification bytes sit at the top of the 4 KB window, so a driver can find the block by probing it.

Reads are combinational from the block's state. Read data is zero whenever no read is selected. Writes take effect at the rising clock edge.

Top module: `rtc_sec_match`

## Requirements
- R1: After reset, the count, match, preset, mask and raw flag all read 0, and `irq_o` is low.
- R2: A tick occurs once every `CLK_HZ` clocks; the first tick comes `CLK_HZ` clocks after reset is released. Each tick adds one to the count, and the count wraps from 0xFFFFFFFF to 0. Without a tick the count holds.
- R3: A write to offset 0x008 (preset) stores the value, which reads back at 0x008. It also replaces the count at the same edge; the count reads back at offset 0x000.
- R4: The raw flag (bit 0 of offset 0x014) sets when a tick moves the count onto the value held at 0x004 (match). A match value equal to the current count does not fire until the count has wrapped all the way round. Writing the match register never fires the flag by itself.
- R5: The mask at offset 0x010 keeps only bit 0 of the written value, and reads back as that bit.
- R6: A write to offset 0x01C with bit 0 set clears the raw flag; a write with bit 0 clear leaves the flag alone. If a clear and a new match happen in the same cycle, the flag stays set.
- R7: Offset 0x018 reads raw AND mask. `irq_o` is high exactly while that value is 1, and it drops in the cycle after the mask is written to 0.
- R8: Offset 0x00C always reads 1. Writes to 0x000, 0x00C, 0x014, 0x018 and the ID locations change no state.
- R9: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read bytes 0 to 3 of 0x00141031. Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read bytes 0 to 3 of 0xB105F00D. Each byte is returned in bits [7:0], with the upper bits zero.
- R10: A read of any other offset returns 0, and `rdata_o` is 0 whenever no read is selected. Address bits [1:0] are ignored.
- R11: If a preset write and a tick fall in the same cycle, the preset value wins and no match is evaluated in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access select |
| we_i | input | 1 | 1 = write, 0 = read (valid with `sel_i`) |
| addr_i | input | 12 | Byte offset within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when not reading |
| irq_o | output | 1 | Level-high interrupt, raw AND mask |

## Verification
The assertions assume that the bus inputs are known after reset and hold steady across each rising edge. They also assume that a single access means one cycle of `sel_i`, and that the two low address bits are zero. The bench keeps within these limits by changing inputs only on falling edges and holding each access for one full cycle. It lines up preset and clear writes with the tick using its own model of the prescaler phase, which makes the same-cycle collisions happen on purpose rather than by chance. It never leaves the select high across two edges unless it means to write twice.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int IW = AW - 2;

  // word indices (byte offset >> 2)
  localparam logic [IW-1:0] W_DATA  = IW'(10'h000);
  localparam logic [IW-1:0] W_MATCH = IW'(10'h001);
  localparam logic [IW-1:0] W_LOAD  = IW'(10'h002);
  localparam logic [IW-1:0] W_CTRL  = IW'(10'h003);
  localparam logic [IW-1:0] W_MASK  = IW'(10'h004);
  localparam logic [IW-1:0] W_RAW   = IW'(10'h005);
  localparam logic [IW-1:0] W_MIS   = IW'(10'h006);
  localparam logic [IW-1:0] W_CLR   = IW'(10'h007);
  localparam logic [IW-1:0] W_ID    = IW'(10'h3F8);

  localparam logic [DW-1:0] PERIPH_ID = 32'h0014_1031;
  localparam logic [DW-1:0] CELL_ID   = 32'hB105_F00D;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + PW'(1);
      end

      assign tick_o = (pre_q == LAST);

      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_sec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_we_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] match_i,
  output logic [DW-1:0] count_o,
  output logic          raw_o
);
  logic [DW-1:0] count_q, count_nx;
  logic          raw_q, adv, hit;

  assign adv      = tick_i & ~load_we_i;  // preset beats tick
  assign count_nx = count_q + DW'(1);
  assign hit      = adv && (count_nx == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (load_we_i) count_q <= wdata_i;
    else if (adv)       count_q <= count_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     raw_q <= 1'b0;
    else if (hit)                    raw_q <= 1'b1;  // set beats clear
    else if (clr_we_i && wdata_i[0]) raw_q <= 1'b0;
  end

  assign count_o = count_q;
  assign raw_o   = raw_q;

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> count_q == $past(wdata_i));
  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_we_i) |=> count_q == $past(count_q) + DW'(1));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_we_i) |=> count_q == $past(count_q));
  p_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_we_i && (count_q + DW'(1) == match_i)) |=> raw_q);
  p_load_nomatch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_we_i && !clr_we_i) |=> raw_q == $past(raw_q));
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wdata_i[0] && !tick_i) |=> !raw_q);
endmodule

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs
  import rtc_sec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] count_i,
  input  logic          raw_i,
  output logic [DW-1:0] rdata_o,
  output logic          load_we_o,
  output logic          clr_we_o,
  output logic [DW-1:0] match_o,
  output logic          mask_o
);
  logic [IW-1:0] idx;
  logic          wr, unused_lsb;
  logic [DW-1:0] match_q, load_q, rd, id_word;
  logic          mask_q;

  assign idx        = addr_i[AW-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign wr         = sel_i & we_i;
  assign load_we_o  = wr && (idx == W_LOAD);
  assign clr_we_o   = wr && (idx == W_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      load_q  <= '0;
      mask_q  <= 1'b0;
    end else if (wr) begin
      if (idx == W_MATCH) match_q <= wdata_i;
      if (idx == W_LOAD)  load_q  <= wdata_i;
      if (idx == W_MASK)  mask_q  <= wdata_i[0];
    end
  end

  assign id_word = idx[2] ? CELL_ID : PERIPH_ID;

  always_comb begin
    rd = '0;
    case (idx)
      W_DATA:  rd = count_i;
      W_MATCH: rd = match_q;
      W_LOAD:  rd = load_q;
      W_CTRL:  rd = DW'(1);
      W_MASK:  rd = DW'(mask_q);
      W_RAW:   rd = DW'(raw_i);
      W_MIS:   rd = DW'(raw_i & mask_q);
      default: begin
        if (idx[IW-1:3] == W_ID[IW-1:3])
          rd = DW'(8'(id_word >> (8 * idx[1:0])));
      end
    endcase
  end

  assign rdata_o = (sel_i && !we_i) ? rd : '0;
  assign match_o = match_q;
  assign mask_o  = mask_q;

  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == W_MASK) |=> mask_q == $past(wdata_i[0]));
  p_match_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx != W_MATCH) |=> match_q == $past(match_q));
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i) |-> rdata_o == '0);
endmodule

// File: rtl/rtc_sec_match.sv
module rtc_sec_match
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          tick, load_we, clr_we, raw, mask;
  logic [DW-1:0] count, match;

  rtc_tick_gen #(.DIV(CLK_HZ)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  rtc_sec_core i_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .load_we_i(load_we), .clr_we_i(clr_we), .wdata_i(wdata_i),
    .match_i(match), .count_o(count), .raw_o(raw)
  );

  rtc_sec_regs i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(count), .raw_i(raw),
    .rdata_o(rdata_o), .load_we_o(load_we), .clr_we_o(clr_we),
    .match_o(match), .mask_o(mask)
  );

  assign irq_o = raw & mask;

  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i[AW-1:2] == W_MASK && !wdata_i[0]) |=> !irq_o);
endmodule

// File: tb/test_rtc_sec_match.sv
module test_rtc_sec_match;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, bad = 0;

  // behavioural reference state
  logic [31:0] m_cnt, m_match, m_load;
  bit          m_mask, m_raw;
  int          m_pre;

  rtc_sec_match #(.CLK_HZ(DIV)) i_rtc_sec_match (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin : model
    bit tk, hit, wr;
    int idx;
    if (!rst_n) begin
      m_cnt = 0; m_match = 0; m_load = 0; m_mask = 0; m_raw = 0; m_pre = 0;
    end else begin
      tk  = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      wr  = sel && we;
      idx = int'(addr) / 4;
      hit = 0;
      if (wr && idx == 2) begin
        m_cnt = wdata; m_load = wdata;
      end else if (tk) begin
        m_cnt = m_cnt + 1;
        hit = (m_cnt == m_match);
      end
      if (wr && idx == 1) m_match = wdata;
      if (wr && idx == 4) m_mask = wdata[0];
      if (hit) m_raw = 1;
      else if (wr && idx == 7 && wdata[0]) m_raw = 0;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] pid = 32'h0014_1031, cid = 32'hB105_F00D;
    case (int'(a) & 32'hFFC)
      'h000: return m_cnt;
      'h004: return m_match;
      'h008: return m_load;
      'h00C: return 1;
      'h010: return {31'd0, m_mask};
      'h014: return {31'd0, m_raw};
      'h018: return {31'd0, m_raw & m_mask};
      'hFE0: return {24'd0, pid[7:0]};
      'hFE4: return {24'd0, pid[15:8]};
      'hFE8: return {24'd0, pid[23:16]};
      'hFEC: return {24'd0, pid[31:24]};
      'hFF0: return {24'd0, cid[7:0]};
      'hFF4: return {24'd0, cid[15:8]};
      'hFF8: return {24'd0, cid[23:16]};
      'hFFC: return {24'd0, cid[31:24]};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 chk(req, rdata, exp_rd(a));
    sel = 0; addr = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0; addr = '0; wdata = '0;
  endtask

  // write landing on the same edge as a tick
  task automatic wr_on_tick(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    while (m_pre != DIV - 1) @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0; addr = '0; wdata = '0;
  endtask

  // R7: interrupt line compared with model on every clock
  always @(negedge clk) if (rst_n) chk("R7 irq", {31'd0, irq}, {31'd0, m_raw & m_mask});

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1;
    // R1 reset state
    rd("R1 data", 12'h000); rd("R1 match", 12'h004); rd("R1 load", 12'h008);
    rd("R1 mask", 12'h010); rd("R1 raw", 12'h014); rd("R1 mis", 12'h018);
    // R2 counting
    repeat (3 * DIV + 1) @(negedge clk);
    rd("R2 count", 12'h000);
    repeat (5 * DIV) @(negedge clk);
    rd("R2 count later", 12'h000);
    // R10 idle read data
    @(negedge clk); #1 chk("R10 idle rdata", rdata, 32'd0);
    // R8 control and ignored writes
    rd("R8 ctrl", 12'h00C);
    wr(12'h00C, 32'h0); wr(12'h000, 32'hDEAD_BEEF); wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h018, 32'hFFFF_FFFF); wr(12'hFE0, 32'h55); wr(12'hFF4, 32'h55);
    rd("R8 ctrl after write", 12'h00C); rd("R8 data untouched", 12'h000);
    rd("R8 raw untouched", 12'h014); rd("R8 match untouched", 12'h004);
    rd("R8 id untouched", 12'hFE0);
    // R9 identification bytes
    for (int i = 0; i < 8; i++) rd("R9 id", 12'(12'hFE0 + 4 * i));
    // R10 unassigned and low address bits
    rd("R10 gap", 12'h020); rd("R10 gap", 12'h100); rd("R10 gap", 12'hFDC);
    rd("R10 low bits", 12'h00F);
    // R3 preset
    wr(12'h008, 32'h0000_1234);
    rd("R3 load", 12'h008); rd("R3 data", 12'h000);
    // R5 mask bit 0 only
    wr(12'h010, 32'hFFFF_FFFF); rd("R5 mask set", 12'h010);
    wr(12'h010, 32'hFFFF_FFFE); rd("R5 mask clr", 12'h010);
    // R4 match fires, R7 masked status
    wr(12'h004, 32'd103); wr(12'h008, 32'd100); wr(12'h010, 32'd1);
    repeat (4 * DIV + 2) @(negedge clk);
    rd("R4 raw set", 12'h014); rd("R7 mis", 12'h018);
    chk("R4 raw expected", {31'd0, m_raw}, 32'd1);
    // R7 mask off drops line
    wr(12'h010, 32'd0); rd("R7 mis masked", 12'h018);
    wr(12'h010, 32'd1);
    // R6 clear
    wr(12'h01C, 32'hFFFF_FFFE); rd("R6 clr bit0 zero", 12'h014);
    wr(12'h01C, 32'd1); rd("R6 cleared", 12'h014);
    // R4 match equal to count: no fire
    wr(12'h004, 32'd500); wr(12'h008, 32'd500);
    repeat (6 * DIV) @(negedge clk);
    rd("R4 equal no fire", 12'h014);
    chk("R4 equal raw", {31'd0, m_raw}, 32'd0);
    // R2 wrap onto match 0
    wr(12'h004, 32'd0); wr(12'h008, 32'hFFFF_FFFF);
    repeat (DIV + 1) @(negedge clk);
    rd("R2 wrap data", 12'h000); rd("R4 wrap raw", 12'h014);
    chk("R2 wrap raw", {31'd0, m_raw}, 32'd1);
    wr(12'h01C, 32'd1);
    // R11 preset on tick edge suppresses match
    wr(12'h004, 32'h300);
    wr_on_tick(12'h008, 32'h2FF);
    wr_on_tick(12'h008, 32'h50);
    rd("R11 data", 12'h000); rd("R11 raw", 12'h014);
    chk("R11 raw none", {31'd0, m_raw}, 32'd0);
    // R6 clear on match edge keeps flag
    wr(12'h004, 32'h61);
    wr_on_tick(12'h008, 32'h60);
    wr_on_tick(12'h01C, 32'd1);
    rd("R6 set wins", 12'h014);
    chk("R6 set wins model", {31'd0, m_raw}, 32'd1);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule